// File: doc/BRIEF.md
# Dual-Converter Timestamp Interleaver

Two converters sample one analog input on opposite phases of a shared conversion clock. Each delivers a word of 16 lanes per fabric clock, and each lane holds one sample. One control bit in each lane flags the sample taken at the system reference event. The block finds that flagged lane in each stream and realigns the stream so that the flagged sample becomes element 0 of an aligned word. It writes the aligned words into a short per-converter buffer, and the buffer's write address restarts at the flagged word.

A single read address drains both buffers together. Each output word holds 32 samples, taken alternately from converter 0 and converter 1, with converter 0 always treated as the earlier one. The block absorbs a lead or lag of up to 8 samples between the two streams. It raises a sticky fault when a reference flag never arrives or arrives at a lane other than the one locked. A synchronous resync input clears the fault and waits for fresh flags.

Top module: `ilv_dual_interleave`

## Requirements
- R1: Each 16-bit input lane carries its 12-bit sample in bits [15:4] and the reference flag in bit 0. Bits [3:1] have no effect on any output.
- R2: In the first valid output word, lane 0 is converter 0's flagged sample and lane 1 is converter 1's flagged sample. The flagged lane is the lowest-numbered lane with bit 0 set.
- R3: Output lane 2j holds aligned converter-0 sample j, and output lane 2j+1 holds aligned converter-1 sample j, for j = 0..15. Output lane i occupies out_data[12*i+11:12*i].
- R4: Alignment is exact for any skew from 8 samples of converter-1 lag to 8 samples of converter-1 lead. This holds whether or not the two flags fall in the same input word.
- R5: out_valid is low until both converters have locked. Call the word holding the later of the two first flags word L. out_valid first reads high right after the clock edge that captures input word L+2+START_DELAY.
- R6: Once high, out_valid stays high every cycle until resync. Successive valid words carry successive aligned words, so each lane advances by 32 samples per word.
- R7: After lock, further flags at the locked lane have no effect. A flag at any other lane sets align_err right after the edge that captures it, and streaming carries on.
- R8: If a converter has not locked within TIMEOUT clock edges after reset or resync, align_err is high right after edge TIMEOUT and low after edge TIMEOUT-1. Edges are counted from the resync edge, which is edge 0.
- R9: align_err stays high until resync. After the edge that samples resync high, align_err and out_valid are low and both converters wait for new flags. Flags present during the resync cycle are ignored.
- R10: After reset, out_valid, align_err and out_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Synchronous re-arm of alignment and clear of the fault |
| dev0_data | input | 256 | Converter 0 word: 16 lanes of 16 bits, lane 0 in the low bits |
| dev1_data | input | 256 | Converter 1 word, same layout |
| out_data | output | 384 | 32 interleaved 12-bit samples, lane 0 in the low bits |
| out_valid | output | 1 | out_data holds aligned, interleaved samples |
| align_err | output | 1 | Sticky alignment fault |

## Verification
The write-address window assertion relies on two conditions in the inputs. The two converters must flag the same absolute sample instant, and their stream offset must stay within 8 samples. Under those conditions, both buffers start writing within one clock of each other and their write addresses never differ by more than one. The stimulus meets both conditions by design. It derives both ramps from one time base, places each flag at the same ramp instant and uses offsets only in the range -8 to +8. The single fault case adds a flag at a wrong lane, which leaves the write addresses untouched.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned DEF_LANES      = 16;
    localparam int unsigned DEF_LANE_W     = 16;
    localparam int unsigned DEF_SAMPLE_W   = 12;
    localparam int unsigned DEF_SAMPLE_LSB = 4;
    localparam int unsigned DEF_FLAG_BIT   = 0;
    localparam int unsigned DEF_FIFO_WORDS = 8;
    localparam int unsigned DEF_TIMEOUT    = 64;
    localparam int unsigned DEF_START_DLY  = 1;

    // Address width that never collapses to zero bits
    function automatic int unsigned width_of(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ilv_marker_find.sv
module ilv_marker_find #(
    parameter int unsigned LANES    = ilv_pkg::DEF_LANES,
    parameter int unsigned LANE_W   = ilv_pkg::DEF_LANE_W,
    parameter int unsigned FLAG_BIT = ilv_pkg::DEF_FLAG_BIT,
    parameter int unsigned IDX_W    = ilv_pkg::width_of(LANES)
) (
    input  logic [LANES*LANE_W-1:0] word,
    output logic                    hit,
    output logic [IDX_W-1:0]        pos
);

    logic [LANES-1:0] flags;

    for (genvar g = 0; g < LANES; g++) begin : g_flag
        assign flags[g] = word[g*LANE_W + FLAG_BIT];
    end

    // Lowest flagged lane wins
    always_comb begin
        hit = |flags;
        pos = '0;
        for (int i = int'(LANES) - 1; i >= 0; i--) begin
            if (flags[i]) pos = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ilv_lane_align.sv
module ilv_lane_align #(
    parameter int unsigned LANES      = ilv_pkg::DEF_LANES,
    parameter int unsigned LANE_W     = ilv_pkg::DEF_LANE_W,
    parameter int unsigned SAMPLE_W   = ilv_pkg::DEF_SAMPLE_W,
    parameter int unsigned SAMPLE_LSB = ilv_pkg::DEF_SAMPLE_LSB,
    parameter int unsigned FLAG_BIT   = ilv_pkg::DEF_FLAG_BIT,
    parameter int unsigned TIMEOUT    = ilv_pkg::DEF_TIMEOUT,
    parameter int unsigned AW         = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        resync,
    input  logic [LANES*LANE_W-1:0]     in_word,
    output logic                        wr_en,
    output logic [AW-1:0]               wr_addr,
    output logic [LANES*SAMPLE_W-1:0]   wr_data,
    output logic                        locked,
    output logic                        err
);

    localparam int unsigned IDX_W  = ilv_pkg::width_of(LANES);
    localparam int unsigned TO_W   = ilv_pkg::width_of(TIMEOUT + 1);
    localparam int unsigned WORD_W = LANES * SAMPLE_W;

    typedef struct packed {
        logic [WORD_W-1:0] prev;
        logic [IDX_W-1:0]  off;
        logic              locked;
        logic              err;
        logic [AW-1:0]     wptr;
        logic [TO_W-1:0]   wait_cnt;
    } align_st_t;

    align_st_t st_d, st_q;

    logic [WORD_W-1:0] cur_flat;
    logic              hit;
    logic [IDX_W-1:0]  pos;

    for (genvar g = 0; g < LANES; g++) begin : g_samp
        assign cur_flat[g*SAMPLE_W +: SAMPLE_W] = in_word[g*LANE_W + SAMPLE_LSB +: SAMPLE_W];
    end

    ilv_marker_find #(
        .LANES(LANES), .LANE_W(LANE_W), .FLAG_BIT(FLAG_BIT), .IDX_W(IDX_W)
    ) u_find (
        .word(in_word), .hit(hit), .pos(pos)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur_flat;
        if (resync) begin
            st_d.locked   = 1'b0;
            st_d.err      = 1'b0;
            st_d.wptr     = '0;
            st_d.wait_cnt = '0;
        end else if (!st_q.locked) begin
            if (hit) begin
                st_d.locked   = 1'b1;
                st_d.off      = pos;
                st_d.wptr     = '0;
                st_d.wait_cnt = '0;
            end else if (st_q.wait_cnt == TO_W'(TIMEOUT - 1)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.wait_cnt = st_q.wait_cnt + 1'b1;
            end
        end else begin
            st_d.wptr = st_q.wptr + 1'b1;
            if (hit && (pos != st_q.off)) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Aligned word: lanes off..LANES-1 of the held word, then lanes 0..off-1 of the live word
    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            int idx;
            idx = i + int'(st_q.off);
            if (idx < int'(LANES))
                wr_data[i*SAMPLE_W +: SAMPLE_W] = st_q.prev[idx*SAMPLE_W +: SAMPLE_W];
            else
                wr_data[i*SAMPLE_W +: SAMPLE_W] = cur_flat[(idx-int'(LANES))*SAMPLE_W +: SAMPLE_W];
        end
    end

    assign wr_en   = st_q.locked;
    assign wr_addr = st_q.wptr;
    assign locked  = st_q.locked;
    assign err     = st_q.err;

endmodule

// File: rtl/ilv_skew_fifo.sv
module ilv_skew_fifo #(
    parameter int unsigned WORD_W     = 192,
    parameter int unsigned FIFO_WORDS = ilv_pkg::DEF_FIFO_WORDS,
    parameter int unsigned AW         = ilv_pkg::width_of(FIFO_WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [FIFO_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ilv_dual_interleave.sv
module ilv_dual_interleave #(
    parameter int unsigned LANES       = ilv_pkg::DEF_LANES,
    parameter int unsigned LANE_W      = ilv_pkg::DEF_LANE_W,
    parameter int unsigned SAMPLE_W    = ilv_pkg::DEF_SAMPLE_W,
    parameter int unsigned SAMPLE_LSB  = ilv_pkg::DEF_SAMPLE_LSB,
    parameter int unsigned FLAG_BIT    = ilv_pkg::DEF_FLAG_BIT,
    parameter int unsigned FIFO_WORDS  = ilv_pkg::DEF_FIFO_WORDS,
    parameter int unsigned TIMEOUT     = ilv_pkg::DEF_TIMEOUT,
    parameter int unsigned START_DELAY = ilv_pkg::DEF_START_DLY
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          resync,
    input  logic [LANES*LANE_W-1:0]       dev0_data,
    input  logic [LANES*LANE_W-1:0]       dev1_data,
    output logic [2*LANES*SAMPLE_W-1:0]   out_data,
    output logic                          out_valid,
    output logic                          align_err
);

    localparam int unsigned AW     = ilv_pkg::width_of(FIFO_WORDS);
    localparam int unsigned WORD_W = LANES * SAMPLE_W;
    localparam int unsigned OUT_W  = 2 * WORD_W;
    localparam int unsigned CW     = ilv_pkg::width_of(START_DELAY + 1);
    localparam int unsigned NDEV   = 2;

    typedef struct packed {
        logic              run;
        logic [CW-1:0]     dly;
        logic [AW-1:0]     rptr;
        logic              valid;
        logic [OUT_W-1:0]  data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    logic [LANES*LANE_W-1:0] dev_word [NDEV];
    logic [NDEV-1:0]         wr_en;
    logic [AW-1:0]           wr_addr  [NDEV];
    logic [WORD_W-1:0]       wr_data  [NDEV];
    logic [WORD_W-1:0]       rd_data  [NDEV];
    logic [NDEV-1:0]         dev_lock;
    logic [NDEV-1:0]         dev_err;
    logic [OUT_W-1:0]        mix;

    assign dev_word[0] = dev0_data;
    assign dev_word[1] = dev1_data;

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        ilv_lane_align #(
            .LANES(LANES), .LANE_W(LANE_W), .SAMPLE_W(SAMPLE_W),
            .SAMPLE_LSB(SAMPLE_LSB), .FLAG_BIT(FLAG_BIT),
            .TIMEOUT(TIMEOUT), .AW(AW)
        ) u_align (
            .clk(clk), .rst_n(rst_n), .resync(resync),
            .in_word(dev_word[d]),
            .wr_en(wr_en[d]), .wr_addr(wr_addr[d]), .wr_data(wr_data[d]),
            .locked(dev_lock[d]), .err(dev_err[d])
        );

        ilv_skew_fifo #(
            .WORD_W(WORD_W), .FIFO_WORDS(FIFO_WORDS), .AW(AW)
        ) u_fifo (
            .clk(clk), .wr_en(wr_en[d]), .wr_addr(wr_addr[d]),
            .wr_data(wr_data[d]), .rd_addr(rd_q.rptr), .rd_data(rd_data[d])
        );
    end

    // Converter 0 takes even output lanes, converter 1 odd
    for (genvar j = 0; j < LANES; j++) begin : g_mix
        assign mix[(2*j)*SAMPLE_W   +: SAMPLE_W] = rd_data[0][j*SAMPLE_W +: SAMPLE_W];
        assign mix[(2*j+1)*SAMPLE_W +: SAMPLE_W] = rd_data[1][j*SAMPLE_W +: SAMPLE_W];
    end

    always_comb begin
        rd_d = rd_q;
        if (resync) begin
            rd_d.run   = 1'b0;
            rd_d.dly   = '0;
            rd_d.rptr  = '0;
            rd_d.valid = 1'b0;
            rd_d.data  = '0;
        end else begin
            if ((&dev_lock) && !rd_q.run) begin
                if (rd_q.dly == CW'(START_DELAY)) rd_d.run = 1'b1;
                else                              rd_d.dly = rd_q.dly + 1'b1;
            end
            if (rd_q.run) begin
                rd_d.valid = 1'b1;
                rd_d.data  = mix;
                rd_d.rptr  = rd_q.rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign out_data  = rd_q.data;
    assign out_valid = rd_q.valid;
    assign align_err = |dev_err;

endmodule

// File: rtl/ilv_dual_interleave_chk.sv
module ilv_dual_interleave_chk #(
    parameter int unsigned AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          resync,
    input logic          out_valid,
    input logic          align_err,
    input logic [1:0]    dev_lock,
    input logic [1:0]    wen,
    input logic [AW-1:0] waddr0,
    input logic [AW-1:0] waddr1
);

    logic [AW-1:0] wdiff;
    assign wdiff = waddr0 - waddr1;

    assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (&dev_lock));

    assert_valid_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !resync) |=> out_valid);

    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_lock[0] && !resync) |=> dev_lock[0]);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err && !resync) |=> align_err);

    assert_resync_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (!out_valid && !align_err && !dev_lock[1]));

    assert_skew_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&wen) |-> (wdiff == '0 || wdiff == AW'(1) || wdiff == '1));

endmodule

bind ilv_dual_interleave ilv_dual_interleave_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .resync(resync),
    .out_valid(out_valid), .align_err(align_err),
    .dev_lock(dev_lock), .wen(wr_en),
    .waddr0(wr_addr[0]), .waddr1(wr_addr[1])
);

// File: tb/ilv_dual_interleave_test.sv
`timescale 1ns/1ps
module ilv_dual_interleave_test;

    localparam int LANES = 16;
    localparam int LW    = 16;
    localparam int SW    = 12;
    localparam int TO    = 64;
    localparam int SD    = 1;
    localparam int OW    = 2*LANES*SW;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               resync = 1'b0;
    logic [LANES*LW-1:0] dev0_data = '0;
    logic [LANES*LW-1:0] dev1_data = '0;
    logic [OW-1:0]      out_data;
    logic               out_valid;
    logic               align_err;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ilv_dual_interleave #(.TIMEOUT(TO), .START_DELAY(SD)) uut (
        .clk(clk), .rst_n(rst_n), .resync(resync),
        .dev0_data(dev0_data), .dev1_data(dev1_data),
        .out_data(out_data), .out_valid(out_valid), .align_err(align_err)
    );

    task automatic chk_bit(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_word(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Stream word w of one converter. Absolute instant a = position minus skew for converter 1.
    // Value = 2*(a+16)+dev; flag at instant t and every 64 after; bits [3:1] carry junk (R1).
    function automatic logic [LANES*LW-1:0] mk_word(int dev, int w, int d, int t, int bad_lane);
        logic [LANES*LW-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            int p, a, v;
            logic f;
            p = 16*w + l;
            a = (dev == 0) ? p : p - d;
            v = 2*(a + 16) + dev;
            f = (a >= t) && (((a - t) % 64) == 0);
            if (l == bad_lane) f = 1'b1;
            r[l*LW +: LW] = {v[11:0], 3'((l + 3*dev + 5) % 8), f};
        end
        return r;
    endfunction

    task automatic do_resync();
        @(negedge clk);
        resync = 1'b1;
        dev0_data = mk_word(0, 0, 0, 0, -1);
        dev1_data = mk_word(1, 0, 0, 0, -1);
        @(posedge clk);
        #1;
        chk_bit("R9 valid cleared by resync", out_valid, 1'b0);
        chk_bit("R9 error cleared by resync", align_err, 1'b0);
        @(negedge clk);
        resync = 1'b0;
    endtask

    // One aligned run; bad_w >= 0 adds a flag at a wrong converter-1 lane in that word
    task automatic run_align(input string tag, input int t, input int d, input int bad_w, input int bad_lane);
        int lw, first, nw;
        lw = ((t / 16) > ((t + d) / 16)) ? (t / 16) : ((t + d) / 16);
        first = lw + 2 + SD;
        nw = lw + 14;
        do_resync();
        for (int w = 0; w < nw; w++) begin
            logic [OW-1:0] exp;
            bit ev, ee;
            if (w > 0) @(negedge clk);
            dev0_data = mk_word(0, w, d, t, -1);
            dev1_data = mk_word(1, w, d, t, (w == bad_w) ? bad_lane : -1);
            @(posedge clk);
            #1;
            ev = (w >= first);
            ee = (bad_w >= 0) && (w >= bad_w);
            chk_bit(ev ? {tag, " R6 valid held"} : {tag, " R5 valid before start"}, out_valid, ev);
            chk_bit(ee ? {tag, " R7 R9 sticky error"} : {tag, " R7 no error"}, align_err, ee);
            if (ev) begin
                int r;
                r = w - first;
                for (int i = 0; i < 2*LANES; i++)
                    exp[i*SW +: SW] = SW'(2*(t + 16) + 32*r + i);
                chk_word(r == 0 ? {tag, " R2 first word"} : {tag, " R3 R4 interleave"}, out_data, exp);
            end
        end
    endtask

    task automatic run_timeout();
        do_resync();
        for (int k = 1; k <= TO + 2; k++) begin
            if (k > 1) @(negedge clk);
            dev0_data = '0;
            dev1_data = '0;
            @(posedge clk);
            #1;
            chk_bit("R8 timeout error", align_err, (k >= TO));
            chk_bit("R8 no valid without lock", out_valid, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_bit("R10 reset valid", out_valid, 1'b0);
        chk_bit("R10 reset error", align_err, 1'b0);
        chk_word("R10 reset data", out_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_bit("R10 valid after release", out_valid, 1'b0);

        run_align("R1 skew 0", 40, 0, -1, -1);
        run_align("skew +3", 45, 3, -1, -1);
        run_align("skew +8 across words", 60, 8, -1, -1);
        run_align("skew -8 across words", 33, -8, -1, -1);
        run_align("skew -5", 47, -5, -1, -1);
        run_align("wrong lane", 40, 3, 7, 5);
        run_timeout();
        run_align("recover after timeout", 36, 2, -1, -1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule